// File: doc/BRIEF.md
# Four-Entry Instruction TLB with Pairwise LRU Refill

This block is a small, fully associative instruction translation cache of four entries. Each cycle it can take one lookup: a virtual address, an address-space identifier and a flag that enables identifier checking. It answers in the same cycle with hit, miss or multiple-hit, the index of the entry involved, and the translated physical address on a hit. Every entry covers a page of 1 KB, 4 KB, 64 KB or 1 MB.

When a lookup misses, refill is enabled and the larger unified TLB next to it reports a hit on its refill port, the supplied entry is written into a victim slot at the next clock edge. The held lookup then hits that slot. The victim comes from a 6-bit pairwise recency code. Every hit and every refill updates that code with a fixed set/clear mask for the entry used. The code is also a field of a control register, so it can be read and overwritten directly.

Top module: `itlb4_lru`

## Requirements
- R1: After reset no entry is valid and `lru_state` is 0, so every lookup misses.
- R2: An entry matches only when it is valid and the address lies in its page. The page size code is 0=1 KB, 1=4 KB, 2=64 KB, 3=1 MB. The page base is the stored page number shifted left by 10, with the bits below the page size ignored.
- R3: With `req_asid_chk`=1 an entry also needs `ent asid == req_asid`, unless its shared bit is 1. With `req_asid_chk`=0 the identifier is not compared.
- R4: When two or more entries match, `rsp_multi` is 1, `rsp_hit`=0, `rsp_fill`=0, `rsp_paddr`=0, and `lru_state` does not change.
- R5: On a hit, `rsp_idx` is the matching entry. `rsp_paddr` is the stored frame number shifted left by 10 with the in-page bits cleared, OR-ed with the in-page bits of the address. Without a hit `rsp_paddr` is 0.
- R6: A miss with `req_fill_en`=1 and `fill_hit`=1 raises `rsp_fill` with `rsp_idx` = victim. The victim entry is loaded from the fill port at the clock edge, and the same lookup hits that entry in the next cycle. Without both enables nothing is written.
- R7: The victim is the first that applies of: entry 0 if bits 5,4,3 are all 1; entry 1 if bit5=0, bit2=0, bit1=1; entry 2 if bit4=0, bit2=0, bit0=1; entry 3 if bits 3,1,0 are all 0. If none applies, the victim is entry 0.
- R8: On each hit or refill, the entry used updates `lru_state` at the clock edge. Entry 0 clears bits 5,4,3. Entry 1 sets bit 5 and clears bits 2,1. Entry 2 sets bits 4,2 and clears bit 0. Entry 3 sets bits 3,1,0. Without a hit, refill or write the code holds.
- R9: `lru_wr`=1 loads `lru_wdata` into `lru_state` at the clock edge. This write wins over an update in the same cycle.
- R10: With `req_valid`=0 all `rsp_*` outputs are 0 and nothing is updated. With `req_valid`=1 exactly one of hit, miss and multi is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request present |
| req_vaddr | input | VA_W | Virtual address to translate |
| req_asid | input | ASID_W | Address-space identifier of the request |
| req_asid_chk | input | 1 | Compare identifiers when 1 |
| req_fill_en | input | 1 | Allow refill on a miss |
| fill_hit | input | 1 | Unified TLB holds a matching entry |
| fill_vpn | input | VA_W-10 | Page number of the supplied entry |
| fill_ppn | input | PA_W-10 | Frame number of the supplied entry |
| fill_size | input | 2 | Page size code of the supplied entry |
| fill_asid | input | ASID_W | Identifier of the supplied entry |
| fill_shared | input | 1 | Shared bit of the supplied entry |
| lru_wr | input | 1 | Control-register write of the recency code |
| lru_wdata | input | 6 | Value written to the recency code |
| rsp_hit | output | 1 | Exactly one entry matched |
| rsp_miss | output | 1 | No entry matched |
| rsp_multi | output | 1 | Several entries matched |
| rsp_fill | output | 1 | Refill into the victim this cycle |
| rsp_idx | output | 2 | Hit entry, or victim during a refill |
| rsp_paddr | output | PA_W | Translated physical address |
| lru_state | output | 6 | Current recency code |

## Verification
The assertions assume that the refill port offers an entry which covers the address being looked up. They also assume that a request held across a refill keeps its address and identifier fields. The bench follows both rules: every refill page is built from the lookup address itself, and each lookup is driven unchanged for a whole cycle. The bench writes arbitrary recency codes only through the control port. This keeps the victim-fallback case apart from states that updates alone can reach. The multi-hit case is made only by refilling an overlapping 1 MB page, because a refill can only occur on a miss.

// File: rtl/itlb_pkg.sv
package itlb_pkg;
   localparam int N_WAYS    = 4;
   localparam int IDX_W     = $clog2(N_WAYS);
   localparam int LRU_W     = 6;
   localparam int PG_LSB    = 10;
   localparam int OFF_MAX_W = 20;

   typedef enum logic [1:0] {
      PG_1K  = 2'd0,
      PG_4K  = 2'd1,
      PG_64K = 2'd2,
      PG_1M  = 2'd3
   } pg_size_e;

   function automatic logic [OFF_MAX_W-1:0] page_off_mask(input pg_size_e sz);
      case (sz)
         PG_1K:   return 20'h003FF;
         PG_4K:   return 20'h00FFF;
         PG_64K:  return 20'h0FFFF;
         default: return 20'hFFFFF;
      endcase
   endfunction

   // bits forced to one when an entry is used
   function automatic logic [LRU_W-1:0] lru_set_mask(input logic [IDX_W-1:0] idx);
      case (idx)
         2'd1:    return 6'b100000;
         2'd2:    return 6'b010100;
         2'd3:    return 6'b001011;
         default: return 6'b000000;
      endcase
   endfunction

   // bits forced to zero when an entry is used
   function automatic logic [LRU_W-1:0] lru_clr_mask(input logic [IDX_W-1:0] idx);
      case (idx)
         2'd0:    return 6'b111000;
         2'd1:    return 6'b000110;
         2'd2:    return 6'b000001;
         default: return 6'b000000;
      endcase
   endfunction
endpackage

// File: rtl/itlb_match.sv
module itlb_match
   import itlb_pkg::*;
#(
   parameter int VA_W   = 32,
   parameter int PA_W   = 29,
   parameter int ASID_W = 8
) (
   input  logic                    ent_v,
   input  logic [VA_W-PG_LSB-1:0]  ent_vpn,
   input  logic [PA_W-PG_LSB-1:0]  ent_ppn,
   input  logic [1:0]              ent_sz,
   input  logic [ASID_W-1:0]       ent_asid,
   input  logic                    ent_sh,
   input  logic [VA_W-1:0]         va,
   input  logic [ASID_W-1:0]       asid,
   input  logic                    asid_chk,
   output logic                    hit,
   output logic [PA_W-1:0]         pa
);
   logic [OFF_MAX_W-1:0] off_m;
   logic [VA_W-1:0]      va_hi_m;
   logic [PA_W-1:0]      pa_hi_m;
   logic [VA_W-1:0]      base;
   logic [PA_W-1:0]      frame;
   logic                 asid_ok;

   always_comb begin
      off_m   = page_off_mask(pg_size_e'(ent_sz));
      va_hi_m = ~{{(VA_W-OFF_MAX_W){1'b0}}, off_m};
      pa_hi_m = ~{{(PA_W-OFF_MAX_W){1'b0}}, off_m};
      base    = {ent_vpn, {PG_LSB{1'b0}}};
      frame   = {ent_ppn, {PG_LSB{1'b0}}};
      asid_ok = !asid_chk || ent_sh || (ent_asid == asid);
      hit     = ent_v && asid_ok && ((va & va_hi_m) == (base & va_hi_m));
      pa      = (frame & pa_hi_m)
              | {{(PA_W-OFF_MAX_W){1'b0}}, va[OFF_MAX_W-1:0] & off_m};
   end
endmodule

// File: rtl/itlb_lru.sv
module itlb_lru
   import itlb_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [LRU_W-1:0] wdata,
   input  logic             use_en,
   input  logic [IDX_W-1:0] use_idx,
   output logic [LRU_W-1:0] state,
   output logic [IDX_W-1:0] victim
);
   logic [LRU_W-1:0] st_q;
   logic [LRU_W-1:0] st_upd;

   always_comb begin
      st_upd = (st_q | lru_set_mask(use_idx)) & ~lru_clr_mask(use_idx);
   end

   // fixed patterns checked in order; fallback to entry 0
   always_comb begin
      if (st_q[5] && st_q[4] && st_q[3])
         victim = 2'd0;
      else if (!st_q[5] && !st_q[2] && st_q[1])
         victim = 2'd1;
      else if (!st_q[4] && !st_q[2] && st_q[0])
         victim = 2'd2;
      else if (!st_q[3] && !st_q[1] && !st_q[0])
         victim = 2'd3;
      else
         victim = 2'd0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         st_q <= '0;
      else if (wr)
         st_q <= wdata;
      else if (use_en)
         st_q <= st_upd;
   end

   assign state = st_q;
endmodule

// File: rtl/itlb4_lru.sv
module itlb4_lru
   import itlb_pkg::*;
#(
   parameter int VA_W   = 32,
   parameter int PA_W   = 29,
   parameter int ASID_W = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   req_valid,
   input  logic [VA_W-1:0]        req_vaddr,
   input  logic [ASID_W-1:0]      req_asid,
   input  logic                   req_asid_chk,
   input  logic                   req_fill_en,
   input  logic                   fill_hit,
   input  logic [VA_W-PG_LSB-1:0] fill_vpn,
   input  logic [PA_W-PG_LSB-1:0] fill_ppn,
   input  logic [1:0]             fill_size,
   input  logic [ASID_W-1:0]      fill_asid,
   input  logic                   fill_shared,
   input  logic                   lru_wr,
   input  logic [LRU_W-1:0]       lru_wdata,
   output logic                   rsp_hit,
   output logic                   rsp_miss,
   output logic                   rsp_multi,
   output logic                   rsp_fill,
   output logic [IDX_W-1:0]       rsp_idx,
   output logic [PA_W-1:0]        rsp_paddr,
   output logic [LRU_W-1:0]       lru_state
);
   localparam int VPN_W = VA_W - PG_LSB;
   localparam int PPN_W = PA_W - PG_LSB;
   localparam int CNT_W = IDX_W + 1;

   if (N_WAYS != 4) begin : g_bad_ways
      $error("recency code is defined for exactly four entries");
   end
   if (VA_W <= OFF_MAX_W || PA_W <= OFF_MAX_W) begin : g_bad_width
      $error("address widths must exceed the largest page offset");
   end
   if (ASID_W < 1) begin : g_bad_asid
      $error("identifier width must be positive");
   end

   logic              ent_v    [N_WAYS];
   logic [VPN_W-1:0]  ent_vpn  [N_WAYS];
   logic [PPN_W-1:0]  ent_ppn  [N_WAYS];
   logic [1:0]        ent_sz   [N_WAYS];
   logic [ASID_W-1:0] ent_asid [N_WAYS];
   logic              ent_sh   [N_WAYS];

   logic [N_WAYS-1:0] m_hit;
   logic [PA_W-1:0]   m_pa [N_WAYS];

   for (genvar g = 0; g < N_WAYS; g++) begin : g_way
      itlb_match #(
         .VA_W   (VA_W),
         .PA_W   (PA_W),
         .ASID_W (ASID_W)
      ) u_match (
         .ent_v    (ent_v[g]),
         .ent_vpn  (ent_vpn[g]),
         .ent_ppn  (ent_ppn[g]),
         .ent_sz   (ent_sz[g]),
         .ent_asid (ent_asid[g]),
         .ent_sh   (ent_sh[g]),
         .va       (req_vaddr),
         .asid     (req_asid),
         .asid_chk (req_asid_chk),
         .hit      (m_hit[g]),
         .pa       (m_pa[g])
      );
   end

   logic [CNT_W-1:0] n_hit;
   logic [IDX_W-1:0] h_idx;
   logic [PA_W-1:0]  pa_or;
   logic [IDX_W-1:0] victim;
   logic             upd_en;

   always_comb begin
      n_hit = '0;
      h_idx = '0;
      pa_or = '0;
      for (int i = 0; i < N_WAYS; i++) begin
         if (m_hit[i]) begin
            n_hit = n_hit + CNT_W'(1);
            h_idx = IDX_W'(i);
            pa_or = pa_or | m_pa[i];
         end
      end
   end

   always_comb begin
      rsp_hit   = req_valid && (n_hit == CNT_W'(1));
      rsp_miss  = req_valid && (n_hit == '0);
      rsp_multi = req_valid && (n_hit > CNT_W'(1));
      rsp_fill  = rsp_miss && req_fill_en && fill_hit;
      rsp_idx   = rsp_hit ? h_idx : (rsp_fill ? victim : '0);
      rsp_paddr = rsp_hit ? pa_or : '0;
      upd_en    = rsp_hit || rsp_fill;
   end

   itlb_lru u_lru (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (lru_wr),
      .wdata   (lru_wdata),
      .use_en  (upd_en),
      .use_idx (rsp_idx),
      .state   (lru_state),
      .victim  (victim)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < N_WAYS; i++) begin
            ent_v[i]    <= 1'b0;
            ent_vpn[i]  <= '0;
            ent_ppn[i]  <= '0;
            ent_sz[i]   <= '0;
            ent_asid[i] <= '0;
            ent_sh[i]   <= 1'b0;
         end
      end else if (rsp_fill) begin
         ent_v[victim]    <= 1'b1;
         ent_vpn[victim]  <= fill_vpn;
         ent_ppn[victim]  <= fill_ppn;
         ent_sz[victim]   <= fill_size;
         ent_asid[victim] <= fill_asid;
         ent_sh[victim]   <= fill_shared;
      end
   end
endmodule

// File: rtl/itlb4_lru_chk.sv
module itlb4_lru_chk
   import itlb_pkg::*;
#(
   parameter int VA_W   = 32,
   parameter int PA_W   = 29,
   parameter int ASID_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic [VA_W-1:0]   req_vaddr,
   input logic [ASID_W-1:0] req_asid,
   input logic              req_asid_chk,
   input logic              req_fill_en,
   input logic              fill_hit,
   input logic              lru_wr,
   input logic [LRU_W-1:0]  lru_wdata,
   input logic              rsp_hit,
   input logic              rsp_miss,
   input logic              rsp_multi,
   input logic              rsp_fill,
   input logic [IDX_W-1:0]  rsp_idx,
   input logic [PA_W-1:0]   rsp_paddr,
   input logic [LRU_W-1:0]  lru_state
);
   assert_one_outcome_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({rsp_hit, rsp_miss, rsp_multi}) == (req_valid ? 1 : 0));

   assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |-> !rsp_fill && rsp_idx == '0 && rsp_paddr == '0);

   assert_fill_needs_miss_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_fill |-> rsp_miss && req_fill_en && fill_hit);

   assert_refill_hits_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_fill |=> (!(req_valid && $stable(req_vaddr) && $stable(req_asid)
                      && $stable(req_asid_chk)))
                   || (rsp_hit && rsp_idx == $past(rsp_idx)));

   assert_multi_no_touch_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_multi && !lru_wr |=> $stable(lru_state));

   assert_paddr_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_hit |-> rsp_paddr == '0);

   assert_victim0_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_fill && lru_state[5:3] == 3'b111 |-> rsp_idx == 2'd0);

   assert_use0_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_hit || rsp_fill) && rsp_idx == 2'd0 && !lru_wr |=> lru_state[5:3] == 3'b000);

   assert_use3_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_hit || rsp_fill) && rsp_idx == 2'd3 && !lru_wr
      |=> lru_state[3] && lru_state[1] && lru_state[0]);

   assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_hit && !rsp_fill && !lru_wr |=> $stable(lru_state));

   assert_write_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      lru_wr |=> lru_state == $past(lru_wdata));
endmodule

bind itlb4_lru itlb4_lru_chk #(
   .VA_W   (VA_W),
   .PA_W   (PA_W),
   .ASID_W (ASID_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .req_valid    (req_valid),
   .req_vaddr    (req_vaddr),
   .req_asid     (req_asid),
   .req_asid_chk (req_asid_chk),
   .req_fill_en  (req_fill_en),
   .fill_hit     (fill_hit),
   .lru_wr       (lru_wr),
   .lru_wdata    (lru_wdata),
   .rsp_hit      (rsp_hit),
   .rsp_miss     (rsp_miss),
   .rsp_multi    (rsp_multi),
   .rsp_fill     (rsp_fill),
   .rsp_idx      (rsp_idx),
   .rsp_paddr    (rsp_paddr),
   .lru_state    (lru_state)
);

// File: tb/tb_itlb4_lru.sv
module tb_itlb4_lru;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [31:0] req_vaddr = '0;
   logic [7:0]  req_asid = '0;
   logic        req_asid_chk = 1'b0;
   logic        req_fill_en = 1'b0;
   logic        fill_hit = 1'b0;
   logic [21:0] fill_vpn = '0;
   logic [18:0] fill_ppn = '0;
   logic [1:0]  fill_size = '0;
   logic [7:0]  fill_asid = '0;
   logic        fill_shared = 1'b0;
   logic        lru_wr = 1'b0;
   logic [5:0]  lru_wdata = '0;
   logic        rsp_hit, rsp_miss, rsp_multi, rsp_fill;
   logic [1:0]  rsp_idx;
   logic [28:0] rsp_paddr;
   logic [5:0]  lru_state;

   int tests = 0;
   int fails = 0;

   always #2 clk = ~clk;

   itlb4_lru dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
      .req_asid(req_asid), .req_asid_chk(req_asid_chk), .req_fill_en(req_fill_en),
      .fill_hit(fill_hit), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
      .fill_size(fill_size), .fill_asid(fill_asid), .fill_shared(fill_shared),
      .lru_wr(lru_wr), .lru_wdata(lru_wdata), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
      .rsp_multi(rsp_multi), .rsp_fill(rsp_fill), .rsp_idx(rsp_idx),
      .rsp_paddr(rsp_paddr), .lru_state(lru_state)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic drive(input logic [31:0] va, input logic [7:0] asid, input logic achk,
                        input logic fen, input logic fh);
      req_valid = 1'b1; req_vaddr = va; req_asid = asid; req_asid_chk = achk;
      req_fill_en = fen; fill_hit = fh;
   endtask

   task automatic idle();
      req_valid = 1'b0; req_fill_en = 1'b0; fill_hit = 1'b0;
   endtask

   // combinational look with no clock edge while the request is up
   task automatic probe(input string tag, input logic [31:0] va, input logic [7:0] asid,
                        input logic achk, input logic fen, input logic ehit, input logic emiss,
                        input logic emulti, input logic efill, input logic [1:0] eidx,
                        input logic [31:0] epa);
      @(negedge clk);
      drive(va, asid, achk, fen, fen);
      #1;
      chk({tag, " hit"},   32'(rsp_hit),   32'(ehit));
      chk({tag, " miss"},  32'(rsp_miss),  32'(emiss));
      chk({tag, " multi"}, 32'(rsp_multi), 32'(emulti));
      chk({tag, " fill"},  32'(rsp_fill),  32'(efill));
      chk({tag, " idx"},   32'(rsp_idx),   32'(eidx));
      chk({tag, " paddr"}, 32'(rsp_paddr), epa);
      idle();
   endtask

   // lookup held across one clock edge
   task automatic touch(input logic [31:0] va, input logic [7:0] asid, input logic achk,
                        input logic fen, input logic fh);
      @(negedge clk);
      drive(va, asid, achk, fen, fh);
      @(posedge clk);
      #1;
      idle();
   endtask

   task automatic chk_lru(input string tag, input logic [5:0] exp);
      @(negedge clk);
      #1;
      chk(tag, 32'(lru_state), 32'(exp));
   endtask

   task automatic probe_victim(input string tag, input logic [1:0] exp);
      probe(tag, 32'h0090_0000, 8'd5, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, exp, 32'h0);
   endtask

   task automatic do_fill(input string tag, input logic [31:0] va, input logic [7:0] asid,
                          input logic [21:0] vpn, input logic [18:0] ppn, input logic [1:0] sz,
                          input logic [7:0] fasid, input logic sh, input logic [1:0] eidx,
                          input logic [31:0] epa, input logic [5:0] elru);
      @(negedge clk);
      drive(va, asid, 1'b1, 1'b1, 1'b1);
      fill_vpn = vpn; fill_ppn = ppn; fill_size = sz; fill_asid = fasid; fill_shared = sh;
      #1;
      chk({tag, " R6 fill"},      32'(rsp_fill), 32'd1);
      chk({tag, " R7 victim"},    32'(rsp_idx),  32'(eidx));
      @(posedge clk);
      #1;
      chk({tag, " R6 rehit"},     32'(rsp_hit),  32'd1);
      chk({tag, " R6 rehit idx"}, 32'(rsp_idx),  32'(eidx));
      chk({tag, " R5 paddr"},     32'(rsp_paddr), epa);
      idle();
      chk_lru({tag, " R8 lru"}, elru);
   endtask

   task automatic wr_lru(input string tag, input logic [5:0] val, input logic with_hit);
      @(negedge clk);
      lru_wr = 1'b1; lru_wdata = val;
      if (with_hit) drive(32'h0001_2ABC, 8'd5, 1'b1, 1'b0, 1'b0);
      @(posedge clk);
      #1;
      lru_wr = 1'b0;
      idle();
      chk({tag, " R9 load"}, 32'(lru_state), 32'(val));
   endtask

   task automatic t_reset();
      chk_lru("R1 lru after reset", 6'h00);
      probe("R1 empty", 32'h0001_2000, 8'd5, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 32'h0);
   endtask

   task automatic t_fills();
      do_fill("F3", 32'h0001_2000, 8'd5, 22'h48,   19'h100, 2'd1, 8'd5, 1'b0, 2'd3, 32'h0004_0000, 6'h0B);
      do_fill("F1", 32'h0040_0000, 8'd5, 22'h1015, 19'hC2A, 2'd3, 8'd5, 1'b0, 2'd1, 32'h0030_0000, 6'h29);
      do_fill("F2", 32'h0003_0400, 8'd7, 22'hC1,   19'h255, 2'd0, 8'd7, 1'b1, 2'd2, 32'h0009_5400, 6'h3C);
      do_fill("F0", 32'h0005_0000, 8'd5, 22'h140,  19'h800, 2'd2, 8'd5, 1'b0, 2'd0, 32'h0020_0000, 6'h04);
   endtask

   task automatic t_translate();
      probe("R5 4K",      32'h0001_2ABC, 8'd5, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 2'd3, 32'h0004_0ABC);
      probe("R2 1M",      32'h004A_BCDE, 8'd5, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 2'd1, 32'h003A_BCDE);
      probe("R3 shared",  32'h0003_07FF, 8'd9, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 2'd2, 32'h0009_57FF);
      probe("R2 1K end",  32'h0003_0800, 8'd7, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 32'h0);
      probe("R2 64K top", 32'h0005_FFFF, 8'd5, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 32'h0020_FFFF);
      probe("R2 64K end", 32'h0006_0000, 8'd5, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 32'h0);
      probe("R3 asid ne", 32'h0001_2ABC, 8'd6, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 32'h0);
      probe("R3 no chk",  32'h0001_2ABC, 8'd6, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 2'd3, 32'h0004_0ABC);
      @(negedge clk);
      req_valid = 1'b0; req_vaddr = 32'h0001_2ABC; req_asid = 8'd5; req_fill_en = 1'b1; fill_hit = 1'b1;
      #1;
      chk("R10 idle outputs", 32'({rsp_hit, rsp_miss, rsp_multi, rsp_fill, rsp_idx, rsp_paddr}), 32'h0);
      idle();
      chk_lru("R10 idle lru", 6'h04);
   endtask

   task automatic t_lru_hits();
      touch(32'h0040_0000, 8'd5, 1'b1, 1'b0, 1'b0);
      chk_lru("R8 use1", 6'h20);
      probe_victim("R7 victim3", 2'd3);
      touch(32'h0001_2000, 8'd5, 1'b1, 1'b0, 1'b0);
      chk_lru("R8 use3", 6'h2B);
      probe_victim("R7 victim2", 2'd2);
      touch(32'h0003_0400, 8'd3, 1'b1, 1'b0, 1'b0);
      chk_lru("R8 use2", 6'h3E);
      probe_victim("R7 victim0", 2'd0);
      touch(32'h0005_0000, 8'd5, 1'b1, 1'b0, 1'b0);
      chk_lru("R8 use0", 6'h06);
      probe_victim("R7 fallback", 2'd0);
   endtask

   task automatic t_lru_write();
      wr_lru("W01", 6'h01, 1'b0);
      probe_victim("R7 after W01", 2'd2);
      wr_lru("W38", 6'h38, 1'b0);
      probe_victim("R7 after W38", 2'd0);
      wr_lru("W02 over hit", 6'h02, 1'b1);
      probe_victim("R9 after W02", 2'd1);
   endtask

   task automatic t_multi();
      do_fill("FM", 32'h0008_0000, 8'd5, 22'h0, 19'h0, 2'd3, 8'd0, 1'b1, 2'd1, 32'h0008_0000, 6'h20);
      probe("R4 multi", 32'h0001_2ABC, 8'd5, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 32'h0);
      touch(32'h0001_2ABC, 8'd5, 1'b1, 1'b1, 1'b1);
      chk_lru("R4 lru kept", 6'h20);
   endtask

   task automatic t_nofill();
      touch(32'h0090_0000, 8'd5, 1'b1, 1'b1, 1'b0);
      chk_lru("R6 no fill_hit lru", 6'h20);
      probe("R6 no fill_hit", 32'h0090_0000, 8'd5, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 32'h0);
      touch(32'h0090_0000, 8'd5, 1'b1, 1'b0, 1'b1);
      chk_lru("R6 no fill_en lru", 6'h20);
      probe("R6 no fill_en", 32'h0090_0000, 8'd5, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 32'h0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_fills();
      t_translate();
      t_lru_hits();
      t_lru_write();
      t_multi();
      t_nofill();
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      #80000;
      tests++;
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule